// File: doc/BRIEF.md
# Dual-Bank Segment Display Write Controller

This block accepts write cycles from a processor bus and keeps the contents of an eight-digit seven-segment display. Each pulse on the write strobe is one write. A mode input sends the byte either to a control register or to digit storage. The control word sets several things: shutdown, decoded or raw format, the glyph scheme for decoded digits, the bank that is written and shown, and a digit address. It also arms one of two kinds of update. A burst update blanks the display and fills all eight digits with the next eight data writes. A single update stores the next data write at the addressed digit only.

Decoded digits keep a 4-bit code in one of two banks. The decimal point of each digit is stored once and is the same for both banks. Raw digits keep a full segment byte. Each digit remembers which format it was last written in. Scan logic reads the display through a combinational port: it gives a digit index and gets back the resolved segment byte and a blank flag.

The write strobe is asynchronous to the system clock. It passes through a two-stage synchronizer and a rising-edge detector before any write takes place.

Top module: `disp_wr_ctrl`

## Requirements
- R1: After reset the control register holds shutdown with no update armed, all digit storage is zero, `blank_o` is 1 and `seg_o` is 0.
- R2: Each rising edge of `wr_i` performs exactly one write, however long the strobe stays high. Mode and data are taken on the third clock edge after the strobe is first sampled high.
- R3: A control write with bit 7 set starts a burst. `blank_o` stays 1 during the burst. The next eight data writes go to digits 0 to 7 in that order, and `blank_o` returns to 0 after the eighth.
- R4: Once a burst or single update has completed, data writes change nothing until a new control word is written.
- R5: A control write with bit 7 clear arms a single update. The next data write is stored only at the digit given by control bits 2..0 (bit 2 is the MSB, value 0 means digit 0), and all other digits keep their contents.
- R6: In decoded format (control bit 5 = 1), a data write stores bits 3..0 in the bank chosen by control bit 3 (1 = bank A, 0 = bank B). Every decoded digit shows the bank named by the latest control word, including one written with no data write after it.
- R7: In a decoded data write, data bit 7 is the decimal point, active low. It is stored once per digit and appears as `seg_o[7]` = 1 whichever bank is shown.
- R8: In raw format (control bit 5 = 0), all 8 data bits are stored and are output unchanged on `seg_o`. The bank bit has no effect on raw digits.
- R9: Each digit keeps the format it was last written in. Control bit 6 chooses the glyph scheme for all decoded digits from the latest control word. Hex (1) gives 0-F. The alternate scheme (0) gives 0-9 and then '-', E, H, L, P and blank for codes A to F. `seg_o[6:0]` is g..a.
- R10: Control bit 4 = 0 puts the block in shutdown: `blank_o` is 1 and `seg_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe from the bus; asynchronous, acts on its rising edge |
| mode_i | input | 1 | 1 = control write, 0 = data write |
| data_i | input | 8 | Write data byte |
| rd_idx_i | input | 3 | Digit index for the scan read port |
| seg_o | output | 8 | Resolved segments of the indexed digit: bit 7 = decimal point, bits 6..0 = g..a |
| blank_o | output | 1 | Display blanked (shutdown or burst in progress) |

## Verification
A write takes effect on the third rising clock edge after the strobe is first sampled high: two synchronizer stages, then the register write. The read port is combinational, so storage changes appear on `seg_o` in that same cycle. For every write, the bench holds the strobe high for four cycles and low for four more. Expected digits are queued only after that, and a monitor applies each index and samples on the falling edge. This leaves at least one full cycle of margin past the due edge. The held-strobe test uses a much longer high phase, to show that there is no second write.

// File: rtl/disp_pkg.sv
package disp_pkg;
  localparam int SEG_W  = 8;
  localparam int NIB_W  = 4;
  localparam int ADDR_W = 3;

  typedef struct packed {
    logic              burst;
    logic              hex;
    logic              dec;
    logic              run;
    logic              bank_a;
    logic [ADDR_W-1:0] addr;
  } ctrl_t;

  // segment order g..a
  function automatic logic [6:0] hex_glyph(input logic [NIB_W-1:0] n);
    case (n)
      4'h0: return 7'h3F; 4'h1: return 7'h06; 4'h2: return 7'h5B; 4'h3: return 7'h4F;
      4'h4: return 7'h66; 4'h5: return 7'h6D; 4'h6: return 7'h7D; 4'h7: return 7'h07;
      4'h8: return 7'h7F; 4'h9: return 7'h6F; 4'hA: return 7'h77; 4'hB: return 7'h7C;
      4'hC: return 7'h39; 4'hD: return 7'h5E; 4'hE: return 7'h79; default: return 7'h71;
    endcase
  endfunction

  function automatic logic [6:0] alt_glyph(input logic [NIB_W-1:0] n);
    case (n)
      4'hA: return 7'h40;
      4'hB: return 7'h79;
      4'hC: return 7'h76;
      4'hD: return 7'h38;
      4'hE: return 7'h73;
      4'hF: return 7'h00;
      default: return hex_glyph(n);
    endcase
  endfunction
endpackage

// File: rtl/disp_wr_sync.sv
module disp_wr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  output logic pulse_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], wr_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign pulse_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/disp_ctrl_seq.sv
module disp_ctrl_seq import disp_pkg::*; #(
  parameter int N_DIG = 8,
  parameter int IDX_W = $clog2(N_DIG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pulse_i,
  input  logic             mode_i,
  input  logic [SEG_W-1:0] data_i,
  output ctrl_t            ctrl_o,
  output logic             we_o,
  output logic [IDX_W-1:0] widx_o,
  output logic             burst_act_o,
  output logic             armed_o,
  output logic [IDX_W-1:0] cnt_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_DIG - 1);

  ctrl_t            ctrl_q;
  logic             burst_q, armed_q;
  logic [IDX_W-1:0] cnt_q;
  logic             ctrl_wr, data_wr;

  assign ctrl_wr = pulse_i & mode_i;
  assign data_wr = pulse_i & ~mode_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      burst_q <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (ctrl_wr) begin
      ctrl_q  <= ctrl_t'(data_i);
      burst_q <= data_i[SEG_W-1];
      armed_q <= ~data_i[SEG_W-1];
      cnt_q   <= '0;
    end else if (data_wr) begin
      if (burst_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) burst_q <= 1'b0;
      end else begin
        armed_q <= 1'b0;
      end
    end
  end

  assign we_o        = data_wr & (burst_q | armed_q);
  assign widx_o      = burst_q ? cnt_q : IDX_W'(ctrl_q.addr);
  assign ctrl_o      = ctrl_q;
  assign burst_act_o = burst_q;
  assign armed_o     = armed_q;
  assign cnt_o       = cnt_q;
endmodule

// File: rtl/disp_digit_store.sv
module disp_digit_store import disp_pkg::*; #(
  parameter int N_DIG = 8,
  parameter int IDX_W = $clog2(N_DIG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [SEG_W-1:0] wdata_i,
  input  logic             dec_i,
  input  logic             bank_a_i,
  input  logic             hex_i,
  input  logic             blank_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [SEG_W-1:0] seg_o
);
  logic [N_DIG-1:0][NIB_W-1:0] nib_a_v, nib_b_v;
  logic [N_DIG-1:0][SEG_W-1:0] raw_v;
  logic [N_DIG-1:0]            dp_v, dec_v;

  for (genvar g = 0; g < N_DIG; g++) begin : g_dig
    logic [NIB_W-1:0] a_q, b_q;
    logic [SEG_W-1:0] raw_q;
    logic             dp_q, dec_q;
    logic             hit;

    assign hit = we_i && (widx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        a_q   <= '0;
        b_q   <= '0;
        raw_q <= '0;
        dp_q  <= 1'b0;
        dec_q <= 1'b0;
      end else if (hit) begin
        dec_q <= dec_i;
        if (dec_i) begin
          if (bank_a_i) a_q <= wdata_i[NIB_W-1:0];
          else          b_q <= wdata_i[NIB_W-1:0];
          dp_q <= ~wdata_i[SEG_W-1];  // point is active low on input
        end else begin
          raw_q <= wdata_i;
        end
      end
    end

    assign nib_a_v[g] = a_q;
    assign nib_b_v[g] = b_q;
    assign raw_v[g]   = raw_q;
    assign dp_v[g]    = dp_q;
    assign dec_v[g]   = dec_q;
  end

  logic [NIB_W-1:0] nib;
  logic [6:0]       glyph;
  logic [SEG_W-1:0] seg;

  always_comb begin
    nib   = bank_a_i ? nib_a_v[rd_idx_i] : nib_b_v[rd_idx_i];
    glyph = hex_i ? hex_glyph(nib) : alt_glyph(nib);
    seg   = dec_v[rd_idx_i] ? {dp_v[rd_idx_i], glyph} : raw_v[rd_idx_i];
    seg_o = blank_i ? '0 : seg;
  end
endmodule

// File: rtl/disp_wr_ctrl.sv
module disp_wr_ctrl import disp_pkg::*; #(
  parameter int N_DIG       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int IDX_W       = $clog2(N_DIG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             mode_i,
  input  logic [SEG_W-1:0] data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [SEG_W-1:0] seg_o,
  output logic             blank_o
);
  logic             wr_pulse, data_we, burst_act, armed;
  logic [IDX_W-1:0] widx, burst_cnt;
  ctrl_t            ctrl_q;

  disp_wr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_i),
    .pulse_o(wr_pulse)
  );

  disp_ctrl_seq #(.N_DIG(N_DIG), .IDX_W(IDX_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pulse_i    (wr_pulse),
    .mode_i     (mode_i),
    .data_i     (data_i),
    .ctrl_o     (ctrl_q),
    .we_o       (data_we),
    .widx_o     (widx),
    .burst_act_o(burst_act),
    .armed_o    (armed),
    .cnt_o      (burst_cnt)
  );

  assign blank_o = ~ctrl_q.run | burst_act;

  disp_digit_store #(.N_DIG(N_DIG), .IDX_W(IDX_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (data_we),
    .widx_i  (widx),
    .wdata_i (data_i),
    .dec_i   (ctrl_q.dec),
    .bank_a_i(ctrl_q.bank_a),
    .hex_i   (ctrl_q.hex),
    .blank_i (blank_o),
    .rd_idx_i(rd_idx_i),
    .seg_o   (seg_o)
  );
endmodule

// File: rtl/disp_wr_ctrl_chk.sv
module disp_wr_ctrl_chk #(
  parameter int N_DIG = 8,
  parameter int IDX_W = $clog2(N_DIG)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_pulse,
  input logic             data_we,
  input logic             burst_act,
  input logic             armed,
  input logic [IDX_W-1:0] burst_cnt,
  input logic             run,
  input logic             blank_o,
  input logic [7:0]       seg_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_DIG - 1);

  AST_PULSE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pulse |=> !wr_pulse); // R2

  AST_BURST_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_act |-> blank_o); // R3

  AST_BURST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we && burst_act && burst_cnt != LAST) |=> (burst_act && burst_cnt == $past(burst_cnt) + 1'b1)); // R3

  AST_BURST_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we && burst_act && burst_cnt == LAST) |=> !burst_act); // R4

  AST_SINGLE_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we && !burst_act) |=> !armed); // R5

  AST_SHUT_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> (blank_o && seg_o == 8'h00)); // R10
endmodule

bind disp_wr_ctrl disp_wr_ctrl_chk #(.N_DIG(N_DIG), .IDX_W(IDX_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_pulse (wr_pulse),
  .data_we  (data_we),
  .burst_act(burst_act),
  .armed    (armed),
  .burst_cnt(burst_cnt),
  .run      (ctrl_q.run),
  .blank_o  (blank_o),
  .seg_o    (seg_o)
);

// File: tb/sim_disp_wr_ctrl.sv
module sim_disp_wr_ctrl;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0;
  logic       mode = 1'b0;
  logic [7:0] data = 8'h00;
  logic [2:0] rd_idx = 3'd0;
  logic [7:0] seg;
  logic       blank;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [2:0] idx;
    logic [7:0] seg;
    logic       blank;
    string      tag;
  } exp_t;

  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_wr_ctrl u0 (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .wr_i    (wr),
    .mode_i  (mode),
    .data_i  (data),
    .rd_idx_i(rd_idx),
    .seg_o   (seg),
    .blank_o (blank)
  );

  function automatic logic [7:0] hexg(input logic [3:0] n);
    case (n)
      4'h0: return 8'h3F; 4'h1: return 8'h06; 4'h2: return 8'h5B; 4'h3: return 8'h4F;
      4'h4: return 8'h66; 4'h5: return 8'h6D; 4'h6: return 8'h7D; 4'h7: return 8'h07;
      4'h8: return 8'h7F; 4'h9: return 8'h6F; 4'hA: return 8'h77; 4'hB: return 8'h7C;
      4'hC: return 8'h39; 4'hD: return 8'h5E; 4'hE: return 8'h79; default: return 8'h71;
    endcase
  endfunction

  task automatic bus_wr(input logic m, input logic [7:0] d, input int hold = 4);
    @(negedge clk);
    mode = m;
    data = d;
    wr   = 1'b1;
    repeat (hold) @(negedge clk);
    wr = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic expect_dig(input logic [2:0] i, input logic [7:0] s, input logic b, input string t);
    exp_t e;
    e.idx = i; e.seg = s; e.blank = b; e.tag = t;
    exp_q.push_back(e);
  endtask

  task automatic drain();
    wait (exp_q.size() == 0);
    @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: applies the index, samples away from the rising edge
  initial begin
    forever begin
      exp_t e;
      wait (exp_q.size() > 0);
      @(negedge clk);
      e = exp_q.pop_front();
      rd_idx = e.idx;
      #1;
      n_chk++;
      if (seg !== e.seg || blank !== e.blank) begin
        n_fail++;
        $display("FAIL %s: digit %0d seg=%h blank=%b, expected seg=%h blank=%b",
                 e.tag, e.idx, seg, blank, e.seg, e.blank);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    expect_dig(3'd0, 8'h00, 1'b1, "R1");
    expect_dig(3'd7, 8'h00, 1'b1, "R1");
    drain();

    // R3 burst, hex, decoded, running, bank A
    bus_wr(1'b1, 8'hF8);
    expect_dig(3'd0, 8'h00, 1'b1, "R3 blank at burst start");
    drain();
    for (int i = 0; i < 7; i++)
      bus_wr(1'b0, (i == 2) ? 8'h03 : (8'h80 | 8'(i + 1)));
    expect_dig(3'd0, 8'h00, 1'b1, "R3 blank after seven writes");
    drain();
    bus_wr(1'b0, 8'h88);
    for (int i = 0; i < 8; i++)
      expect_dig(3'(i), (i == 2) ? (8'h80 | hexg(4'(i + 1))) : hexg(4'(i + 1)), 1'b0, "R3 burst fill");
    drain();

    // R4 extra write after burst ignored
    bus_wr(1'b0, 8'h8F);
    expect_dig(3'd0, hexg(4'h1), 1'b0, "R4");
    expect_dig(3'd1, hexg(4'h2), 1'b0, "R4");
    drain();

    // R6/R7 single update to bank B addr 5; bank B shown everywhere
    bus_wr(1'b1, 8'h75);
    expect_dig(3'd0, 8'h3F, 1'b0, "R6 bank B shown");
    expect_dig(3'd2, 8'hBF, 1'b0, "R7 point kept across bank");
    drain();
    bus_wr(1'b0, 8'h8A);
    expect_dig(3'd5, hexg(4'hA), 1'b0, "R5 addressed digit");
    expect_dig(3'd4, 8'h3F, 1'b0, "R5 other digit kept");
    drain();
    bus_wr(1'b0, 8'h83);
    expect_dig(3'd5, hexg(4'hA), 1'b0, "R5 second write ignored");
    drain();

    // R6 bank A again, control only
    bus_wr(1'b1, 8'h78);
    expect_dig(3'd0, hexg(4'h1), 1'b0, "R6 bank A shown");
    expect_dig(3'd5, hexg(4'h6), 1'b0, "R6 bank A shown");
    drain();

    // R9 alternate glyphs, then hex again
    bus_wr(1'b1, 8'h3C);
    bus_wr(1'b0, 8'h8C);
    expect_dig(3'd4, 8'h76, 1'b0, "R9 alt code C");
    drain();
    bus_wr(1'b1, 8'h78);
    expect_dig(3'd4, hexg(4'hC), 1'b0, "R9 hex applied globally");
    drain();

    // R8 raw store at digit 3
    bus_wr(1'b1, 8'h1B);
    bus_wr(1'b0, 8'h5A);
    expect_dig(3'd3, 8'h5A, 1'b0, "R8 raw byte");
    drain();
    bus_wr(1'b1, 8'h70);
    expect_dig(3'd3, 8'h5A, 1'b0, "R8 bank has no effect on raw");
    expect_dig(3'd4, 8'h3F, 1'b0, "R9 decoded digit follows bank B");
    drain();

    // R2 long strobe in a raw burst: exactly one write
    bus_wr(1'b1, 8'h90);
    bus_wr(1'b0, 8'hAA, 40);
    expect_dig(3'd0, 8'h00, 1'b1, "R2 still blank after one write");
    drain();
    for (int i = 0; i < 7; i++) bus_wr(1'b0, 8'h55);
    expect_dig(3'd0, 8'hAA, 1'b0, "R2 first digit");
    expect_dig(3'd1, 8'h55, 1'b0, "R2 held strobe wrote once");
    expect_dig(3'd7, 8'h55, 1'b0, "R3 last digit");
    drain();

    // R10 shutdown
    bus_wr(1'b1, 8'h68);
    expect_dig(3'd0, 8'h00, 1'b1, "R10");
    expect_dig(3'd7, 8'h00, 1'b1, "R10");
    drain();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule